// File: doc/BRIEF.md
# Show-Ahead Flit Queue

This block is a small synchronous first-in first-out queue meant to sit at an input port of an on-chip network router. It holds up to `LAST_IDX + 1` flits in a ring of registers. A write pointer and a read pointer step through the ring and wrap from the highest slot back to slot 0. The oldest stored flit is always driven onto `flit_out` with no read latency, so a consumer can inspect the head flit and then pop it in the same cycle it decides to.

A three-state controller tracks occupancy and gates each request. The states are `Q_EMPTY` (nothing stored), `Q_PARTIAL` (some slots used) and `Q_FULL` (every slot used). The named transitions are PUSH_FILL (`Q_EMPTY` or `Q_PARTIAL` to `Q_FULL` when a lone write makes the advanced write pointer meet the read pointer), PUSH_GROW (`Q_EMPTY` to `Q_PARTIAL`, or `Q_PARTIAL` staying `Q_PARTIAL`, on a lone write that does not fill the ring), POP_DRAIN (`Q_PARTIAL` or `Q_FULL` to `Q_EMPTY` when a lone read makes the advanced read pointer meet the write pointer), POP_SHRINK (`Q_FULL` to `Q_PARTIAL`, or `Q_PARTIAL` staying, on a lone read that leaves data behind) and SWAP (a combined read and write in `Q_PARTIAL` or `Q_FULL`: both pointers advance and the state does not change). A popped slot is cleared to zero. An empty queue therefore shows zero on `flit_out`.

Top module: `flit_fifo`

## Requirements
- R1: After reset `has_data` is 0, `is_full` is 0 and `flit_out` is 0.
- R2: A lone write stores `flit_in`. `has_data` is 1 from the next cycle on. When the queue was empty, the written flit is on `flit_out` in the next cycle.
- R3: A lone write that occupies the last free slot sets `is_full` in the next cycle. This happens after `LAST_IDX + 1` writes from empty with no reads.
- R4: A lone read removes the head flit and clears its slot, and `is_full` drops to 0. When it removes the last flit, `has_data` drops to 0 and `flit_out` reads 0.
- R5: A combined read and write on a partly filled queue pops the head and appends the new flit. `is_full` and `has_data` are left unchanged.
- R6: A read request on an empty queue is ignored. Both flags and `flit_out` stay 0, and the next write is still the first flit returned.
- R7: A lone write on a full queue is ignored. None of the stored flits is overwritten, which the bench shows by draining the queue afterwards.
- R8: A combined read and write on a full queue is accepted. The head is popped, the new flit is appended and `is_full` stays 1.
- R9: A combined read and write on an empty queue acts as a lone write: the flit is stored and `has_data` becomes 1.
- R10: Flits leave in the order they were accepted, across any number of pointer wraps and under any mix of enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Write request for `flit_in` |
| pop_en | input | 1 | Read request: remove the head flit |
| flit_in | input | DATA_W | Flit to be stored |
| flit_out | output | DATA_W | Head flit, or 0 when empty |
| is_full | output | 1 | All slots occupied |
| has_data | output | 1 | At least one slot occupied (0 means empty) |

## Verification
The embedded properties are evaluated on every cycle. They check that a full queue has its two pointers meeting, that an empty queue drives zero, that an ignored read on empty or lone write on full moves no pointer, that SWAP keeps the state, and that `has_data` rises only after a write request. Data ordering cannot be shown by a property, and neither can the fact that a refused write leaves older flits intact or that wrapping keeps order. Those are shown only by the bench's scoreboard, which replays directed sequences and a long random run against a queue model and compares the head flit and both flags after every clock.

// File: rtl/flitq_pkg.sv
package flitq_pkg;

    // Occupancy states of the queue controller
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_e;

    // Operation actually performed in a cycle after gating
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } qop_e;

endpackage

// File: rtl/flitq_ptr.sv
module flitq_ptr #(
    parameter int DEPTH = 4,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_inc
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam bit POW2 = (DEPTH == (1 << AW));

    generate
        if (POW2) begin : g_pow2
            // Natural rollover of the counter performs the wrap
            assign ptr_inc = ptr + 1'b1;
        end else begin : g_cmp
            assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr_inc;
        end
    end

endmodule

// File: rtl/flitq_store.sv
module flitq_store #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          clr,
    input  logic [AW-1:0] caddr,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] slot_view [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (waddr == AW'(g))) begin
                    // A write wins over a clear of the same slot (swap on full)
                    q <= wdata;
                end else if (clr && (caddr == AW'(g))) begin
                    q <= '0;
                end
            end
            assign slot_view[g] = q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr == AW'(i)) begin
                rdata = slot_view[i];
            end
        end
    end

endmodule

// File: rtl/flitq_ctrl.sv
module flitq_ctrl
    import flitq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] wr_ptr_inc,
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] rd_ptr_inc,
    output logic          do_wr,
    output logic          do_rd,
    output logic          q_full,
    output logic          q_valid
);
    qstate_e state, state_nxt;
    qop_e    op;

    // Gate the requests according to occupancy
    always_comb begin
        do_wr = 1'b0;
        do_rd = 1'b0;
        unique case (state)
            Q_EMPTY: begin
                do_wr = wr_req;
                do_rd = 1'b0;
            end
            Q_PARTIAL: begin
                do_wr = wr_req;
                do_rd = rd_req;
            end
            Q_FULL: begin
                do_rd = rd_req;
                do_wr = wr_req && rd_req;
            end
            default: begin
                do_wr = 1'b0;
                do_rd = 1'b0;
            end
        endcase
    end

    always_comb begin
        unique case ({do_wr, do_rd})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
    end

    // Next-state: flags change only on one-sided operations
    always_comb begin
        state_nxt = state;
        unique case (op)
            OP_PUSH: state_nxt = (wr_ptr_inc == rd_ptr) ? Q_FULL  : Q_PARTIAL;
            OP_POP:  state_nxt = (rd_ptr_inc == wr_ptr) ? Q_EMPTY : Q_PARTIAL;
            OP_SWAP: state_nxt = state;
            default: state_nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        q_full  = 1'b0;
        q_valid = 1'b0;
        unique case (state)
            Q_EMPTY:   begin q_full = 1'b0; q_valid = 1'b0; end
            Q_PARTIAL: begin q_full = 1'b0; q_valid = 1'b1; end
            Q_FULL:    begin q_full = 1'b1; q_valid = 1'b1; end
            default:   begin q_full = 1'b0; q_valid = 1'b0; end
        endcase
    end

    // R6: a lone read on an empty queue leaves it empty
    a_r6_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY && rd_req && !wr_req) |=> (state == Q_EMPTY));

    // R5: a swap on a partly filled queue keeps the state
    a_r5_swap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_PARTIAL && wr_req && rd_req) |=> (state == Q_PARTIAL));

    // R8: a swap on a full queue keeps it full
    a_r8_swap_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL && wr_req && rd_req) |=> (state == Q_FULL));

    // R4: a lone read on a full queue clears full
    a_r4_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL && rd_req && !wr_req) |=> (state != Q_FULL));

endmodule

// File: rtl/flit_fifo.sv
module flit_fifo #(
    parameter int DATA_W   = 16,
    parameter int LAST_IDX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic [DATA_W-1:0] flit_in,
    output logic [DATA_W-1:0] flit_out,
    output logic              is_full,
    output logic              has_data
);
    localparam int DEPTH = LAST_IDX + 1;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          do_wr, do_rd;
    logic [AW-1:0] wr_ptr, wr_ptr_inc, rd_ptr, rd_ptr_inc;

    flitq_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (do_wr),
        .ptr     (wr_ptr),
        .ptr_inc (wr_ptr_inc)
    );

    flitq_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (do_rd),
        .ptr     (rd_ptr),
        .ptr_inc (rd_ptr_inc)
    );

    flitq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (push_en),
        .rd_req     (pop_en),
        .wr_ptr     (wr_ptr),
        .wr_ptr_inc (wr_ptr_inc),
        .rd_ptr     (rd_ptr),
        .rd_ptr_inc (rd_ptr_inc),
        .do_wr      (do_wr),
        .do_rd      (do_rd),
        .q_full     (is_full),
        .q_valid    (has_data)
    );

    flitq_store #(.DEPTH(DEPTH), .W(DATA_W), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr),
        .waddr (wr_ptr),
        .wdata (flit_in),
        .clr   (do_rd),
        .caddr (rd_ptr),
        .raddr (rd_ptr),
        .rdata (flit_out)
    );

    // R3: a full queue has its pointers meeting
    a_r3_full_ptrs_meet: assert property (@(posedge clk) disable iff (!rst_n)
        is_full |-> (wr_ptr == rd_ptr));

    // R4: an empty queue shows a cleared head slot
    a_r4_empty_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !has_data |-> (flit_out == '0));

    // R7: a lone write on a full queue moves no pointer
    a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_en && !pop_en) |=> ($stable(wr_ptr) && $stable(rd_ptr) && is_full));

    // R6: a read request on empty moves no pointer
    a_r6_empty_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_data && pop_en && !push_en) |=> $stable(rd_ptr));

    // R2: data appears only after a write request
    a_r2_valid_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(has_data) |-> $past(push_en));

endmodule

// File: tb/sim_flit_fifo.sv
module sim_flit_fifo;
    localparam int DATA_W   = 16;
    localparam int LAST_IDX = 3;
    localparam int DEPTH    = LAST_IDX + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_en = 1'b0;
    logic              pop_en = 1'b0;
    logic [DATA_W-1:0] flit_in = '0;
    logic [DATA_W-1:0] flit_out;
    logic              is_full;
    logic              has_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [DATA_W-1:0] model_q [$];

    always #5 clk = ~clk;

    flit_fifo #(.DATA_W(DATA_W), .LAST_IDX(LAST_IDX)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .flit_in  (flit_in),
        .flit_out (flit_out),
        .is_full  (is_full),
        .has_data (has_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare outputs with the head of the expected queue
    task automatic monitor(input string req);
        logic [DATA_W-1:0] exp_head;
        exp_head = (model_q.size() > 0) ? model_q[0] : '0;
        check(flit_out == exp_head, req, "flit_out", flit_out, exp_head);
        check(has_data == (model_q.size() > 0), req, "has_data",
              DATA_W'(has_data), DATA_W'(model_q.size() > 0));
        check(is_full == (model_q.size() == DEPTH), req, "is_full",
              DATA_W'(is_full), DATA_W'(model_q.size() == DEPTH));
    endtask

    // Driver: apply one cycle, push/pop expected items by the acceptance rules
    task automatic step(input bit wr, input bit rd, input logic [DATA_W-1:0] d,
                        input string req);
        bit acc_wr, acc_rd;
        int sz;
        @(negedge clk);
        push_en = wr;
        pop_en  = rd;
        flit_in = d;
        sz = model_q.size();
        acc_rd = rd && (sz > 0);
        acc_wr = wr && ((sz < DEPTH) || rd);
        @(posedge clk);
        if (acc_rd) void'(model_q.pop_front());
        if (acc_wr) model_q.push_back(d);
        #2;
        monitor(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        monitor("R1");

        // R6: read while empty is ignored
        step(1'b0, 1'b1, 16'h0000, "R6");
        step(1'b0, 1'b1, 16'h0000, "R6");
        // R2 / R5 / R4: write A, swap with B, read alone
        step(1'b1, 1'b0, 16'h00A1, "R2");
        step(1'b1, 1'b1, 16'h00B2, "R5");
        step(1'b0, 1'b1, 16'h0000, "R4");
        // R9: swap request on empty acts as write
        step(1'b1, 1'b1, 16'h0C03, "R9");
        step(1'b0, 1'b1, 16'h0000, "R4");
        // R3: fill up
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DATA_W'(16'h1000 + i), "R3");
        // R7: write-only while full is ignored
        step(1'b1, 1'b0, 16'hDEAD, "R7");
        step(1'b1, 1'b0, 16'hBEEF, "R7");
        // R8: swap while full stays full
        step(1'b1, 1'b1, 16'h2001, "R8");
        step(1'b1, 1'b1, 16'h2002, "R8");
        // R4 / R7: drain, proving no overwrite happened
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 16'h0000, "R7");
        step(1'b0, 1'b1, 16'h0000, "R6");

        // R10: random mix over many wraps
        for (int i = 0; i < 4000; i++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 DATA_W'($urandom), "R10");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule